// File: doc/BRIEF.md
# Debug Trigger Mode Sequencer

This block turns the per-bus-cycle results of three comparators into one debug trigger. Comparator A and comparator B feed the trigger condition. Comparator C is only recorded. A 4-bit mode field selects how A and B combine. The choices are a single comparator, either of the two, A followed by B in a later bus cycle, both in the same bus cycle, A without B, and two range checks. In the range checks, A signals "address at or above the low bound" and B signals "address at or below the high bound".

Software writes the mode through an 8-bit status/control register. The same register returns three sticky match flags and the mode. A one-cycle arm request opens a capture session and clears all state left over from the previous one. When the selected condition is met in a valid bus cycle while armed, the block emits a single-cycle trigger pulse and disarms itself. It therefore fires at most once per arming.

Top module: `dbg_trig_seq`

## Requirements
- R1: After synchronous reset, `reg_rdata` is 0 (mode 0, all flags clear), `armed` is 0 and `trig` is 0.
- R2: `reg_rdata` bit 7 is the A flag, bit 6 the B flag, bit 5 the C flag, bit 4 reads 0, and bits 3:0 hold the mode. A write stores `reg_wdata[3:0]` into the mode and visible on the cycle after. The written bits 7:4 are ignored.
- R3: A valid bus cycle (`bus_valid`=1) with the block armed sets the flag of each comparator whose hit input is 1. Flags stay set until cleared.
- R4: `arm_req` arms the block, clears all three flags and clears the A-seen sequence state. Hits in the same cycle as `arm_req` are ignored.
- R5: A register write clears all three flags. A hit in a valid armed bus cycle during that same write sets its flag anyway (set wins over the write clear).
- R6: While disarmed, hit inputs are ignored: flags do not change and `trig` stays 0.
- R7: `trig` rises in the cycle after a qualifying bus cycle and lasts exactly one cycle. `armed` drops with it, so no second trigger occurs before the next `arm_req`.
- R8: Mode 0 triggers on A. Mode 1 triggers on A or B. Mode 3 triggers on B. Modes 9 through 15 behave as mode 0.
- R9: In modes 2 and 4, B triggers only in a bus cycle later than one with an A hit since the last arm. A and B together in the first cycle do not trigger.
- R10: Mode 5 triggers when A and B hit in the same bus cycle. Mode 6 triggers when A hits and B does not in the same bus cycle.
- R11: Mode 7 (inside range) triggers when A and B both hit. Mode 8 (outside range) triggers on any valid bus cycle where A and B do not both hit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_req | input | 1 | One-cycle request to start a capture session |
| reg_wr | input | 1 | Write strobe for the status/control register |
| reg_wdata | input | 8 | Write data; only bits 3:0 are stored |
| reg_rdata | output | 8 | Flags in 7:5, zero in 4, mode in 3:0 |
| bus_valid | input | 1 | Hit inputs describe a real bus cycle |
| hit_a | input | 1 | Comparator A result (low bound in range modes) |
| hit_b | input | 1 | Comparator B result (high bound in range modes) |
| hit_c | input | 1 | Comparator C result, recorded only |
| armed | output | 1 | Capture session in progress |
| trig | output | 1 | Single-cycle trigger pulse |

## Verification
Two pairs of events can coincide in one cycle. The first pair is a register write and a comparator hit in an armed bus cycle. The bench issues the write together with a C hit, after an earlier A hit has set the A flag. It then expects the A flag cleared and the C flag set. The second pair is an arm request and a bus cycle carrying hits. The bench expects every flag clear and no trigger, and it checks that a pending A-seen state was discarded by the re-arm.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    M_A_ONLY      = 4'd0,
    M_A_OR_B      = 4'd1,
    M_A_THEN_B    = 4'd2,
    M_B_EVT       = 4'd3,
    M_A_THEN_BEVT = 4'd4,
    M_A_AND_B     = 4'd5,
    M_A_NOT_B     = 4'd6,
    M_IN_RANGE    = 4'd7,
    M_OUT_RANGE   = 4'd8
  } trig_mode_e;

  typedef struct packed {
    logic a_only;
    logic a_or_b;
    logic seq_b;
    logic b_only;
    logic a_and_b;
    logic a_not_b;
    logic in_rng;
    logic out_rng;
  } mode_sel_t;
endpackage

// File: rtl/dbg_mode_decode.sv
module dbg_mode_decode
  import dbg_trig_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output mode_sel_t         sel
);
  always_comb begin
    sel = '0;
    case (mode)
      M_A_OR_B:                    sel.a_or_b  = 1'b1;
      M_A_THEN_B, M_A_THEN_BEVT:   sel.seq_b   = 1'b1;
      M_B_EVT:                     sel.b_only  = 1'b1;
      M_A_AND_B:                   sel.a_and_b = 1'b1;
      M_A_NOT_B:                   sel.a_not_b = 1'b1;
      M_IN_RANGE:                  sel.in_rng  = 1'b1;
      M_OUT_RANGE:                 sel.out_rng = 1'b1;
      default:                     sel.a_only  = 1'b1;  // mode 0 and reserved codes
    endcase
  end
endmodule

// File: rtl/dbg_cond_eval.sv
module dbg_cond_eval
  import dbg_trig_pkg::*;
(
  input  mode_sel_t sel,
  input  logic      a,
  input  logic      b,
  input  logic      seq,
  output logic      hit
);
  logic both;
  assign both = a & b;

  always_comb begin
    hit = (sel.a_only  & a)
        | (sel.a_or_b  & (a | b))
        | (sel.seq_b   & seq & b)
        | (sel.b_only  & b)
        | (sel.a_and_b & both)
        | (sel.a_not_b & a & ~b)
        | (sel.in_rng  & both)
        | (sel.out_rng & ~both);
  end
endmodule

// File: rtl/dbg_seq_track.sv
module dbg_seq_track (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic a_seen,
  output logic seq_q
);
  always_ff @(posedge clk) begin
    if (rst)          seq_q <= 1'b0;
    else if (restart) seq_q <= 1'b0;
    else if (a_seen)  seq_q <= 1'b1;
  end
endmodule

// File: rtl/dbg_match_flags.sv
module dbg_match_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         set_en,
  input  logic [N-1:0] hits,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)                    flags[i] <= 1'b0;
      else if (set_en && hits[i]) flags[i] <= 1'b1;
      else if (clr)               flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq
  import dbg_trig_pkg::*;
#(
  parameter int REG_W   = 8,
  parameter int NUM_CMP = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm_req,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             bus_valid,
  input  logic             hit_a,
  input  logic             hit_b,
  input  logic             hit_c,
  output logic             armed,
  output logic             trig
);
  localparam int PAD_W = REG_W - NUM_CMP - MODE_W;

  logic [MODE_W-1:0]  mode_q;
  logic [NUM_CMP-1:0] flags;
  mode_sel_t          sel;
  logic               seq_q;
  logic               cond_hit;
  logic               live;
  logic               fire;

  // a bus cycle counts only when armed and not being re-armed
  assign live = armed & bus_valid & ~arm_req;
  assign fire = live & cond_hit;

  always_ff @(posedge clk) begin
    if (rst)         mode_q <= '0;
    else if (reg_wr) mode_q <= reg_wdata[MODE_W-1:0];
  end

  dbg_mode_decode u_dec (
    .mode (mode_q),
    .sel  (sel)
  );

  dbg_match_flags #(.N(NUM_CMP)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .clr    (arm_req | reg_wr),
    .set_en (live),
    .hits   ({hit_a, hit_b, hit_c}),
    .flags  (flags)
  );

  dbg_seq_track u_seq (
    .clk     (clk),
    .rst     (rst),
    .restart (arm_req),
    .a_seen  (live & hit_a),
    .seq_q   (seq_q)
  );

  dbg_cond_eval u_cond (
    .sel (sel),
    .a   (hit_a),
    .b   (hit_b),
    .seq (seq_q),
    .hit (cond_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      trig  <= 1'b0;
    end else begin
      trig <= fire;
      if (arm_req)   armed <= 1'b1;
      else if (fire) armed <= 1'b0;
    end
  end

  assign reg_rdata = {flags, {PAD_W{1'b0}}, mode_q};
endmodule

// File: rtl/dbg_trig_seq_chk.sv
module dbg_trig_seq_chk #(
  parameter int REG_W   = 8,
  parameter int NUM_CMP = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             arm_req,
  input logic             reg_wr,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] reg_rdata,
  input logic             bus_valid,
  input logic             armed,
  input logic             trig
);
  localparam int MW = 4;
  logic [NUM_CMP-1:0] fl;
  assign fl = reg_rdata[REG_W-1 -: NUM_CMP];

  AST_TRIG_PULSE: assert property (@(posedge clk) disable iff (rst)
    trig |=> !trig);                                           // R7
  AST_TRIG_DISARMS: assert property (@(posedge clk) disable iff (rst)
    trig |-> !armed);                                          // R7
  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (rst)
    arm_req |=> (fl == '0 && armed));                          // R4
  AST_WR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !arm_req && !(armed && bus_valid)) |=> fl == '0); // R5
  AST_IDLE_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (!armed && !arm_req && !reg_wr) |=> $stable(fl));          // R6
  AST_NO_TRIG_IDLE: assert property (@(posedge clk) disable iff (rst)
    !armed |=> !trig);                                         // R6
  AST_MODE_WRITE: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> reg_rdata[MW-1:0] == $past(reg_wdata[MW-1:0])); // R2
endmodule

bind dbg_trig_seq dbg_trig_seq_chk #(.REG_W(REG_W), .NUM_CMP(NUM_CMP)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .arm_req   (arm_req),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .bus_valid (bus_valid),
  .armed     (armed),
  .trig      (trig)
);

// File: tb/dbg_trig_seq_test.sv
module dbg_trig_seq_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       arm_req = 1'b0, reg_wr = 1'b0, bus_valid = 1'b0;
  logic       hit_a = 1'b0, hit_b = 1'b0, hit_c = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       armed, trig;
  int         tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_trig_seq uut (
    .clk(clk), .rst(rst), .arm_req(arm_req), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
    .hit_a(hit_a), .hit_b(hit_b), .hit_c(hit_c), .armed(armed), .trig(trig)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one cycle of inputs, then sample just after the edge
  task automatic tick(input logic v, input logic a, input logic b, input logic c,
                      input logic arm, input logic wr, input logic [7:0] wd);
    @(negedge clk);
    bus_valid = v; hit_a = a; hit_b = b; hit_c = c;
    arm_req = arm; reg_wr = wr; reg_wdata = wd;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    tick(0, 0, 0, 0, 0, 0, 8'h00);
  endtask

  function automatic logic first_cycle_exp(input int m, input logic a, input logic b);
    case (m)
      1:       return a | b;
      2, 4:    return 1'b0;
      3:       return b;
      5, 7:    return a & b;
      6:       return a & ~b;
      8:       return ~(a & b);
      default: return a;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 rdata", reg_rdata, 8'h00);
    check("R1 armed", {7'd0, armed}, 8'h00);
    check("R1 trig", {7'd0, trig}, 8'h00);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;

    // sweep every mode against every single-cycle hit pattern
    for (int m = 0; m < 16; m++) begin
      for (int v = 0; v < 8; v++) begin
        logic a, b, c, e;
        a = v[2]; b = v[1]; c = v[0];
        e = first_cycle_exp(m, a, b);
        tick(0, 0, 0, 0, 0, 1, {v[2:0], 1'b1, m[3:0]});
        check("R2 write readback", reg_rdata, {4'h0, m[3:0]});
        tick(0, 0, 0, 0, 1, 0, 8'h00);
        check("R4 armed", {7'd0, armed}, 8'h01);
        tick(1, a, b, c, 0, 0, 8'h00);
        check($sformatf("R8/R9/R10/R11 mode %0d hits %0d", m, v), {7'd0, trig}, {7'd0, e});
        check("R3 flags", {5'd0, reg_rdata[7:5]}, {5'd0, a, b, c});
        check("R7 disarm on fire", {7'd0, armed}, {7'd0, ~e});
        idle();
        check("R7 one cycle pulse", {7'd0, trig}, 8'h00);
        if (m == 2 || m == 4) begin
          tick(1, 0, 1, 0, 0, 0, 8'h00);
          check($sformatf("R9 later B mode %0d hits %0d", m, v), {7'd0, trig}, {7'd0, a});
          idle();
        end
      end
    end

    // once per arming, then disarmed inputs ignored
    tick(0, 0, 0, 0, 0, 1, 8'h00);
    tick(0, 0, 0, 0, 1, 0, 8'h00);
    tick(1, 1, 0, 0, 0, 0, 8'h00);
    check("R7 fire", {7'd0, trig}, 8'h01);
    tick(1, 1, 0, 0, 0, 0, 8'h00);
    check("R7 no second trig", {7'd0, trig}, 8'h00);
    tick(1, 1, 1, 1, 0, 0, 8'h00);
    check("R6 flags frozen", {5'd0, reg_rdata[7:5]}, 8'h04);
    check("R6 no trig", {7'd0, trig}, 8'h00);

    // write and hit in the same cycle
    tick(0, 0, 0, 0, 0, 1, 8'h03);
    tick(0, 0, 0, 0, 1, 0, 8'h00);
    tick(1, 1, 0, 0, 0, 0, 8'h00);
    check("R3 A flag set", {5'd0, reg_rdata[7:5]}, 8'h04);
    tick(1, 0, 0, 1, 0, 1, 8'h03);
    check("R5 write clears, hit sets", {5'd0, reg_rdata[7:5]}, 8'h01);
    check("R5 no trig", {7'd0, trig}, 8'h00);

    // arm and hit in the same cycle
    tick(1, 1, 1, 1, 1, 0, 8'h00);
    check("R4 flags clear on arm", {5'd0, reg_rdata[7:5]}, 8'h00);
    check("R4 no trig on arm", {7'd0, trig}, 8'h00);

    // re-arm discards A-seen state in mode 2
    tick(0, 0, 0, 0, 0, 1, 8'h02);
    tick(0, 0, 0, 0, 1, 0, 8'h00);
    tick(1, 1, 0, 0, 0, 0, 8'h00);
    tick(0, 0, 0, 0, 1, 0, 8'h00);
    tick(1, 0, 1, 0, 0, 0, 8'h00);
    check("R9 re-arm drops A", {7'd0, trig}, 8'h00);
    tick(1, 1, 0, 0, 0, 0, 8'h00);
    tick(0, 0, 0, 0, 0, 0, 8'h00);
    tick(1, 0, 1, 0, 0, 0, 8'h00);
    check("R9 A then B after gap", {7'd0, trig}, 8'h01);
    idle();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule